// File: doc/BRIEF.md
# Indirect-Access Backup RAM Bridge

This block lets a host reach a 64-byte scratch RAM and a handful of internal registers through only two host-visible registers. The host picks one with `host_sel`. Select 0 is the command register, which holds an internal register index, a read-launch bit and a busy flag. Select 1 is the data register. Writing the data register starts a write of that byte into the internal register the index names. Writing the command register with bit 7 set starts a read. The result lands in the data register once the busy flag drops.

Every internal access takes a fixed number of clock cycles, set by a parameter. The host polls the busy flag before it issues the next access. There are three internal registers. A control register carries a block-enable bit, which drives an output pin. A pointer register holds the RAM address. A data port reads or writes the RAM at that pointer, and the pointer advances by one after each data-port access. A host can therefore fill or dump the whole RAM with repeated data-port accesses and a single pointer setup.

Top module: `bkram_bridge`

## Requirements
- R1: After reset the command register reads 0x00 (index 0, not busy), the data register reads 0x00, the pointer is 0 and `enable_o` is 0; the RAM contents are undefined.
- R2: Reading the command register (`host_sel`=0) returns {busy, 3'b000, index[3:0]}. A command write while idle with bit 7 clear only loads the index from bits 3:0 and starts no access.
- R3: A data-register write (`host_sel`=1) while idle loads the byte into the data register and starts a write of it into the indexed internal register.
- R4: A command write while idle with bit 7 set loads the index and starts a read. The byte read is in the data register when busy clears.
- R5: Busy (command register bit 7) stays high for exactly LAT consecutive cycles per access, starting in the cycle after the launching write.
- R6: While busy is high, every host write is ignored. Data-register writes and read launches do not take effect, and the index does not change.
- R7: Index 0x6 is the control register. A write stores bit 7 as the block enable, which drives `enable_o`. A read returns {enable, 7'b0}.
- R8: Index 0xE is the RAM pointer. A write keeps only bits 5:0. A read returns {2'b00, pointer}.
- R9: Index 0xF is the RAM data port. A write stores the byte at the pointer, and a read returns the byte at the pointer. The pointer increments by one after each data-port access and wraps from 63 to 0. It changes at no other time except a pointer write.
- R10: Any index other than 0x6, 0xE and 0xF completes normally. A write to it changes nothing, and a read of it returns 0x00.
- R11: After a write access completes, the data register still holds the byte written. Reading either host register has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 1 | Host register select: 0 command, 1 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read value of the selected host register |
| enable_o | output | 1 | Block enable from control register bit 7 |

## Verification
On every cycle, the assertions check four things. The busy window lasts exactly LAT cycles, and every accepted launch raises busy. The index and, during a write access, the data register stay frozen while busy. The pointer moves only at a data-port completion and then by exactly one. Behaviours that depend on what was stored need the bench's scenarios and its cycle-level model. These are the fill-and-dump of all 64 locations, the wrap from 63 to 0, the pointer's masking of high bits, the zero reads of undefined indices and the control-register effect on `enable_o`.

// File: rtl/bkram_pkg.sv
package bkram_pkg;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'h6;
  localparam logic [IDX_W-1:0] IDX_PTR   = 4'hE;
  localparam logic [IDX_W-1:0] IDX_DPORT = 4'hF;
endpackage

// File: rtl/bkram_rst_sync.sv
module bkram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bkram_seq.sv
// Access sequencer: holds busy for LAT cycles and flags the completion cycle.
module bkram_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_wr,
  input  logic launch_rd,
  output logic busy,
  output logic finish,
  output logic op_read
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          rd_q, rd_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (launch_wr || launch_rd) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
      rd_d   = launch_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
    end
  end

  assign busy    = busy_q;
  assign finish  = busy_q && (cnt_q == '0);
  assign op_read = rd_q;
endmodule

// File: rtl/bkram_store.sv
// Scratch array: synchronous write, combinational read, no reset.
module bkram_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bkram_core.sv
// Internal register file: control, pointer and RAM data port.
module bkram_core
  import bkram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     finish,
  input  logic                     op_read,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DW-1:0]            wr_byte,
  output logic [DW-1:0]            rd_byte,
  output logic                     enable_o,
  output logic [$clog2(DEPTH)-1:0] ptr_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             en_q, en_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             hit_ctrl, hit_ptr, hit_port;
  logic             wr_commit, ram_we;
  logic [DW-1:0]    ram_rdata;

  assign hit_ctrl  = (idx == IDX_CTRL);
  assign hit_ptr   = (idx == IDX_PTR);
  assign hit_port  = (idx == IDX_DPORT);
  assign wr_commit = finish && !op_read;
  assign ram_we    = wr_commit && hit_port;

  always_comb begin
    en_d  = en_q;
    ptr_d = ptr_q;
    if (wr_commit && hit_ctrl) en_d = wr_byte[DW-1];
    if (wr_commit && hit_ptr)       ptr_d = wr_byte[PTR_W-1:0];
    else if (finish && hit_port)    ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ptr_q <= '0;
    end else begin
      en_q  <= en_d;
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    rd_byte = '0;
    if (hit_ctrl)      rd_byte = {en_q, {(DW-1){1'b0}}};
    else if (hit_ptr)  rd_byte = DW'(ptr_q);
    else if (hit_port) rd_byte = ram_rdata;
  end

  bkram_store #(.DEPTH(DEPTH), .AW(PTR_W), .DW(DW)) u_store (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ptr_q),
    .wdata (wr_byte),
    .rdata (ram_rdata)
  );

  assign enable_o = en_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/bkram_bridge.sv
module bkram_bridge
  import bkram_pkg::*;
#(
  parameter int LAT       = 4,
  parameter int RAM_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       enable_o
);
  localparam int DW    = 8;
  localparam int PTR_W = $clog2(RAM_DEPTH);

  logic             rst_sync_n;
  logic             busy, finish, op_read;
  logic             accept, launch_wr, launch_rd;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]    data_q, data_d;
  logic [DW-1:0]    rd_byte;
  logic [PTR_W-1:0] ptr;

  bkram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign accept    = host_we && !busy;
  assign launch_wr = accept && host_sel;
  assign launch_rd = accept && !host_sel && host_wdata[DW-1];

  always_comb begin
    idx_d  = idx_q;
    data_d = data_q;
    if (accept && !host_sel) idx_d = host_wdata[IDX_W-1:0];
    if (launch_wr)                data_d = host_wdata;
    else if (finish && op_read)   data_d = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  bkram_seq #(.LAT(LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch_wr (launch_wr),
    .launch_rd (launch_rd),
    .busy      (busy),
    .finish    (finish),
    .op_read   (op_read)
  );

  bkram_core #(.DEPTH(RAM_DEPTH), .DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .finish   (finish),
    .op_read  (op_read),
    .idx      (idx_q),
    .wr_byte  (data_q),
    .rd_byte  (rd_byte),
    .enable_o (enable_o),
    .ptr_o    (ptr)
  );

  assign host_rdata = host_sel ? data_q
                               : {busy, {(DW-1-IDX_W){1'b0}}, idx_q};
endmodule

// File: rtl/bkram_bridge_chk.sv
module bkram_bridge_chk #(
  parameter int LAT   = 4,
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic             host_sel,
  input logic [7:0]       host_wdata,
  input logic             busy,
  input logic             finish,
  input logic             op_read,
  input logic [3:0]       idx,
  input logic [7:0]       data_q,
  input logic [PTR_W-1:0] ptr
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_BUSY_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < LAT) else $error("busy longer than LAT"); // R5
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == LAT) else $error("busy shorter than LAT"); // R5
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_we && (host_sel || host_wdata[7])) |=> busy)
    else $error("launch did not raise busy"); // R3
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(idx)) else $error("index moved while busy"); // R6
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_read) |=> $stable(data_q))
    else $error("data register moved during write access"); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && idx == 4'hF) |=> ptr == PTR_W'($past(ptr) + 1'b1))
    else $error("pointer did not step by one"); // R9
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(ptr)) else $error("pointer moved outside completion"); // R9
endmodule

bind bkram_bridge bkram_bridge_chk #(.LAT(LAT), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_we    (host_we),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .busy       (busy),
  .finish     (finish),
  .op_read    (op_read),
  .idx        (idx_q),
  .data_q     (data_q),
  .ptr        (ptr)
);

// File: tb/bkram_bridge_test.sv
module bkram_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       enable_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkram_bridge #(.LAT(LAT)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .enable_o   (enable_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit model_on = 1'b0;

  // behavioural reference model
  int m_busy, m_idx, m_data, m_ctrl, m_ptr;
  bit m_rd;
  int m_ram [64];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_data = 0; m_ctrl = 0; m_ptr = 0; m_rd = 0;
    end else if (m_busy > 0) begin
      if (m_busy == 1) begin
        if (!m_rd) begin
          if (m_idx == 6)       m_ctrl = m_data & 8'h80;
          else if (m_idx == 14) m_ptr  = m_data & 63;
          else if (m_idx == 15) begin m_ram[m_ptr] = m_data; m_ptr = (m_ptr + 1) % 64; end
        end else begin
          if (m_idx == 6)       m_data = m_ctrl;
          else if (m_idx == 14) m_data = m_ptr;
          else if (m_idx == 15) begin m_data = m_ram[m_ptr]; m_ptr = (m_ptr + 1) % 64; end
          else                  m_data = 0;
        end
      end
      m_busy--;
    end else if (host_we) begin
      if (host_sel) begin
        m_data = host_wdata; m_busy = LAT; m_rd = 0;
      end else begin
        m_idx = host_wdata & 15;
        if (host_wdata[7]) begin m_busy = LAT; m_rd = 1; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (model_on) begin
      check("model readback", host_rdata,
            host_sel ? 8'(m_data) : 8'(((m_busy > 0) ? 128 : 0) | m_idx));
      check("model enable R7", {7'b0, enable_o}, 8'(m_ctrl >> 7));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic host_write(input bit sel, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_idle();
    do begin
      @(negedge clk);
      host_sel = 1'b0;
      #1;
    end while (host_rdata[7]);
  endtask

  task automatic peek(input bit sel, output logic [7:0] v);
    @(negedge clk);
    host_sel = sel;
    #1;
    v = host_rdata;
  endtask

  task automatic int_write(input logic [3:0] idx, input logic [7:0] v);
    host_write(1'b0, {4'h0, idx});
    host_write(1'b1, v);
    wait_idle();
  endtask

  task automatic int_read(input logic [3:0] idx, output logic [7:0] v);
    host_write(1'b0, {4'h8, idx});
    wait_idle();
    peek(1'b1, v);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // R1 reset state
    peek(1'b0, v); check("R1 command reg", v, 8'h00);
    peek(1'b1, v); check("R1 data reg", v, 8'h00);
    check("R1 enable", {7'b0, enable_o}, 8'h00);
    int_read(4'hE, v); check("R1 pointer", v, 8'h00);

    // R2 index load only, high bits dropped
    host_write(1'b0, 8'h7A);
    peek(1'b0, v); check("R2 index readback", v, 8'h0A);

    // R5 busy length, R3 write launch
    host_write(1'b0, 8'h0E);
    host_write(1'b1, 8'h00);
    n = 0;
    host_sel = 1'b0; #1;
    while (host_rdata[7]) begin n++; @(negedge clk); #1; end
    check("R5 busy cycles", 8'(n), 8'(LAT));

    // R7 control register
    int_write(4'h6, 8'hFF);
    check("R7 enable set", {7'b0, enable_o}, 8'h01);
    int_read(4'h6, v); check("R7 ctrl readback R4", v, 8'h80);
    int_write(4'h6, 8'h7F);
    check("R7 enable clear", {7'b0, enable_o}, 8'h00);

    // R8 pointer masking
    int_write(4'hE, 8'hC5);
    int_read(4'hE, v); check("R8 pointer mask", v, 8'h05);

    // R9 fill and dump
    int_write(4'hE, 8'h00);
    host_write(1'b0, 8'h0F);
    for (int i = 0; i < 64; i++) begin
      host_write(1'b1, pat(i));
      wait_idle();
    end
    int_read(4'hE, v); check("R9 pointer wrapped after fill", v, 8'h00);
    for (int i = 0; i < 64; i++) begin
      int_read(4'hF, v); check("R9 dump R4", v, pat(i));
    end
    int_read(4'hE, v); check("R9 pointer after dump", v, 8'h00);

    // R9 wrap 63 -> 0
    int_write(4'hE, 8'h3F);
    host_write(1'b0, 8'h0F);
    host_write(1'b1, 8'hAA); wait_idle();
    host_write(1'b1, 8'hBB); wait_idle();
    int_read(4'hE, v); check("R9 pointer wrap", v, 8'h01);
    int_write(4'hE, 8'h3F);
    int_read(4'hF, v); check("R9 at 63", v, 8'hAA);
    int_read(4'hF, v); check("R9 at 0", v, 8'hBB);

    // R10 undefined indices
    int_write(4'h3, 8'h55);
    peek(1'b1, v); check("R11 data kept after write", v, 8'h55);
    int_read(4'h3, v); check("R10 undefined read", v, 8'h00);
    int_read(4'h9, v); check("R10 undefined read 9", v, 8'h00);
    check("R10 enable untouched", {7'b0, enable_o}, 8'h00);

    // R6 writes ignored while busy
    int_write(4'hE, 8'h10);
    host_write(1'b0, 8'h0F);
    host_write(1'b1, 8'h11);
    host_write(1'b1, 8'h99);
    host_write(1'b0, 8'h86);
    wait_idle();
    peek(1'b1, v); check("R6 data ignored R11", v, 8'h11);
    peek(1'b0, v); check("R6 index ignored", v, 8'h0F);
    int_read(4'hE, v); check("R6 single step", v, 8'h11);
    int_write(4'hE, 8'h10);
    int_read(4'hF, v); check("R3 stored byte", v, 8'h11);
    peek(1'b1, v); peek(1'b1, v);
    int_read(4'hE, v); check("R11 peek no side effect", v, 8'h11);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule